// File: doc/BRIEF.md
# Root Hub Downstream Port Status Register

This block is the control and status register for one downstream port of a USB host controller's root hub. Software reads and writes it as a single 32-bit word. The lower halfword shows the live state of the port: connection, enable, suspend, overcurrent, reset in progress, power and low-speed attachment. The upper halfword holds sticky change flags. A flag stays set until software writes a one to its bit.

A write is a set of one-bit commands. A zero bit never acts, so writes that arrive together can be merged by OR. The block times two sequences itself, using a millisecond tick made from a cycle prescaler:
- **Port reset.** The port is held in reset for a parameterised number of milliseconds.
- **Resume.** Resume signalling runs for a number of milliseconds, then a one-cycle end-of-packet phase, then a resynchronisation wait.

While a bus transaction is in progress (`xact_busy` high), software writes are collected and are not applied until the transaction ends.

Top module: `rh_port_reg`

## Requirements
- R1: The read word has connect status at bit 0, enable at bit 1, suspend at bit 2, overcurrent at bit 3, reset-active at bit 4, power at bit 8 and low-speed at bit 9. Change flags sit at bit 16 (connect), 17 (enable), 18 (suspend), 19 (overcurrent) and 20 (reset). Bits 31:21, 15:10 and 7:5 always read zero, and writing ones to them changes nothing.
- R2: Writing 1 to bit 4 while connected, powered and with no sequence running starts a port reset. Bit 4 then reads 1 for exactly RESET_MS*TICK_CYCLES cycles. On the cycle it falls, bit 20 sets and bit 1 (enable) sets.
- R3: Writing 1 to bit 3 while suspended starts a resume. The sequence is RESUME_MS ms of resume drive, then exactly one cycle of `drv_eop`, then RESYNC_MS ms of resynchronisation. On the cycle that follows, bit 2 clears and bit 18 sets.
- R4: A change flag clears only when a 1 is written to its bit. Writing 0 leaves it set.
- R5: Bit 3 follows `ovc_in` with one cycle of latency. Bit 19 sets on every change of that value.
- R6: Bit 0 follows `connect_in` with one cycle of latency, and bit 16 sets on every change. Bit 9 reads `lowspeed_in` (one cycle late) while connected.
- R7: A disconnect clears enable and suspend and aborts any running sequence. If the port was enabled, it also sets bit 17.
- R8: Asserting `hub_rst_in` clears bit 18.
- R9: A write made while `xact_busy` is high has no effect until the cycle after `xact_busy` falls. Several writes made in that window are merged.
- R10: If a hardware set event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R11: After reset, the whole read word is zero while the inputs are low.
- R12: Command bits act as follows:
  - bit 0 disables the port;
  - bit 1 enables it, and only when connected;
  - bit 2 suspends it, and only when enabled;
  - bit 8 powers it on;
  - bit 9 powers it off, which also clears enable and suspend;
  - a reset request is ignored while the port is unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data (command and write-one-to-clear bits) |
| rd_data | output | 32 | Register read value |
| xact_busy | input | 1 | Bus transaction in progress; writes are held |
| connect_in | input | 1 | Device attached on the port |
| lowspeed_in | input | 1 | Attached device is low speed |
| ovc_in | input | 1 | Overcurrent condition on the port |
| hub_rst_in | input | 1 | Root hub reset-related status; clears the suspend change flag |
| drv_reset | output | 1 | Drive reset signalling on the port |
| drv_resume | output | 1 | Drive resume signalling on the port |
| drv_eop | output | 1 | Drive the end-of-packet closing a resume |

## Verification
The bench steps through the reset and resume sequences one cycle at a time, checking every cycle. An off-by-one in the prescaler or the millisecond counter would show up as a reset bit that falls one cycle early or late, or as an end-of-packet cycle in the wrong place. It aims an overcurrent change and a software clear of the same flag at the same edge; a design that lets the clear win would lose the event. It writes a flag clear while a transaction is running and checks that the flag survives until the transaction ends. It also writes all reserved bits, and writes zero to a set flag, to show that neither has an effect.

// File: rtl/rh_port_pkg.sv
// Shared definitions for the root hub port register: bit positions,
// command bits, reserved mask and sequencer states.
package rh_port_pkg;
    localparam int REG_W   = 32;
    localparam int NFLAGS  = 5;
    localparam int CH_BASE = 16;

    // status bit positions in the read word
    localparam int B_CONN = 0;
    localparam int B_EN   = 1;
    localparam int B_SUSP = 2;
    localparam int B_OVC  = 3;
    localparam int B_RST  = 4;
    localparam int B_PWR  = 8;
    localparam int B_LS   = 9;

    // flag index inside the change vector (read bit = CH_BASE + index)
    localparam int F_CONN = 0;
    localparam int F_EN   = 1;
    localparam int F_SUSP = 2;
    localparam int F_OVC  = 3;
    localparam int F_RST  = 4;

    // command bits in the write word
    localparam int C_DIS  = 0;
    localparam int C_EN   = 1;
    localparam int C_SUSP = 2;
    localparam int C_RES  = 3;
    localparam int C_RST  = 4;
    localparam int C_PON  = 8;
    localparam int C_POFF = 9;

    localparam logic [REG_W-1:0] RSVD_MASK = 32'hFFE0_FCE0;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RESET,
        SEQ_RESUME,
        SEQ_EOP,
        SEQ_RESYNC
    } seq_state_t;
endpackage

// File: rtl/rh_write_gate.sv
// Write postponement. While busy is high, incoming writes are ORed into a
// pending word and nothing is released. In the first cycle with busy low,
// the pending word and any new write are released together as eff_wr.
// Assumes every write bit is a one-acts / zero-ignored command, so OR
// merging is exact.
module rh_write_gate #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         busy,
    output logic [W-1:0] eff_wr
);
    logic [W-1:0] pend_q;
    logic [W-1:0] new_wr;

    // qualify the incoming write
    always_comb new_wr = wr_en ? wr_data : '0;

    // release held plus new writes once the bus is free
    always_comb eff_wr = busy ? '0 : (pend_q | new_wr);

    // accumulate writes while busy, drop them once released
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= '0;
        else if (busy) pend_q <= pend_q | new_wr;
        else           pend_q <= '0;
    end
endmodule

// File: rtl/rh_port_seq.sv
// Port reset and resume sequencer.
// Each timed state lasts DUR * TICK_CYCLES cycles: both the prescaler and
// the millisecond counter restart on every state change. The EOP phase
// lasts one cycle. A start request is ignored unless the sequencer is idle.
// Abort returns to idle at once, without a done pulse.
module rh_port_seq
    import rh_port_pkg::*;
#(
    parameter int TICK_CYCLES = 48000,
    parameter int RESET_MS    = 10,
    parameter int RESUME_MS   = 20,
    parameter int RESYNC_MS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_reset,
    input  logic       start_resume,
    input  logic       abort,
    output seq_state_t state,
    output logic       reset_done,
    output logic       resume_done
);
    localparam int PRE_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int MS_MAX = (RESET_MS > RESUME_MS) ?
                            ((RESET_MS > RESYNC_MS) ? RESET_MS : RESYNC_MS) :
                            ((RESUME_MS > RESYNC_MS) ? RESUME_MS : RESYNC_MS);
    localparam int MS_W   = (MS_MAX > 1) ? $clog2(MS_MAX) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic [MS_W-1:0]  last_ms;
    logic             tick;
    logic             ms_end;
    seq_state_t       nxt;

    // millisecond tick from the prescaler
    always_comb tick = (pre_q == PRE_W'(TICK_CYCLES - 1));

    // final millisecond index of the current timed state
    always_comb begin
        case (state)
            SEQ_RESET:  last_ms = MS_W'(RESET_MS - 1);
            SEQ_RESUME: last_ms = MS_W'(RESUME_MS - 1);
            default:    last_ms = MS_W'(RESYNC_MS - 1);
        endcase
    end

    always_comb ms_end = tick && (ms_q == last_ms);

    // next-state selection and completion pulses
    always_comb begin
        nxt         = state;
        reset_done  = 1'b0;
        resume_done = 1'b0;
        if (abort) begin
            nxt = SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start_reset)       nxt = SEQ_RESET;
                    else if (start_resume) nxt = SEQ_RESUME;
                end
                SEQ_RESET:  if (ms_end) begin nxt = SEQ_IDLE; reset_done = 1'b1; end
                SEQ_RESUME: if (ms_end) nxt = SEQ_EOP;
                SEQ_EOP:    nxt = SEQ_RESYNC;
                SEQ_RESYNC: if (ms_end) begin nxt = SEQ_IDLE; resume_done = 1'b1; end
                default:    nxt = SEQ_IDLE;
            endcase
        end
    end

    // state and timer registers; timers restart on every transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            pre_q <= '0;
            ms_q  <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                pre_q <= '0;
                ms_q  <= '0;
            end else begin
                pre_q <= tick ? '0 : pre_q + 1'b1;
                if (tick) ms_q <= ms_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rh_change_flags.sv
// Sticky change flags. Hardware sets a flag; a clear request clears it.
// A set and a clear in the same cycle leave the flag set.
module rh_change_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // one sticky bit, where set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rh_port_reg.sv
// Status and control register for one root hub downstream port.
// Assumes connect_in, lowspeed_in and ovc_in are already synchronous to
// clk. Writes pass through the postponement gate. The sequencer times the
// reset and resume phases, and change flags use write-one-to-clear with
// set priority.
module rh_port_reg
    import rh_port_pkg::*;
#(
    parameter int TICK_CYCLES = 48000,
    parameter int RESET_MS    = 10,
    parameter int RESUME_MS   = 20,
    parameter int RESYNC_MS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             xact_busy,
    input  logic             connect_in,
    input  logic             lowspeed_in,
    input  logic             ovc_in,
    input  logic             hub_rst_in,
    output logic             drv_reset,
    output logic             drv_resume,
    output logic             drv_eop
);
    logic [REG_W-1:0]  cmd;
    logic [NFLAGS-1:0] flag_set;
    logic [NFLAGS-1:0] flag_clr;
    logic [NFLAGS-1:0] flags;
    logic              conn_q, ovc_q, ls_q, pwr_q, en_q, susp_q;
    logic              disc;
    logic              seq_idle;
    logic              start_reset, start_resume, seq_abort;
    logic              reset_done, resume_done;
    seq_state_t        seq_state;
    logic              unused_cmd;

    rh_write_gate #(.W(REG_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (xact_busy),
        .eff_wr  (cmd)
    );

    // command bits with no function, gathered so they are visibly dropped
    always_comb unused_cmd = ^{cmd[31:21], cmd[15:10], cmd[7:5]};

    // decode of disconnect and sequencer requests
    always_comb begin
        disc         = conn_q && !connect_in;
        seq_idle     = (seq_state == SEQ_IDLE);
        start_reset  = cmd[C_RST] && conn_q && pwr_q;
        start_resume = cmd[C_RES] && susp_q;
        seq_abort    = disc || cmd[C_POFF];
    end

    rh_port_seq #(
        .TICK_CYCLES (TICK_CYCLES),
        .RESET_MS    (RESET_MS),
        .RESUME_MS   (RESUME_MS),
        .RESYNC_MS   (RESYNC_MS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_reset  (start_reset),
        .start_resume (start_resume),
        .abort        (seq_abort),
        .state        (seq_state),
        .reset_done   (reset_done),
        .resume_done  (resume_done)
    );

    // live port status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            ovc_q  <= 1'b0;
            ls_q   <= 1'b0;
            pwr_q  <= 1'b0;
            en_q   <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            conn_q <= connect_in;
            ovc_q  <= ovc_in;
            ls_q   <= lowspeed_in;
            if (cmd[C_POFF])     pwr_q <= 1'b0;
            else if (cmd[C_PON]) pwr_q <= 1'b1;
            if (disc || cmd[C_POFF] || cmd[C_DIS]) en_q <= 1'b0;
            else if (reset_done)                   en_q <= 1'b1;
            else if (cmd[C_EN] && conn_q)          en_q <= 1'b1;
            if (disc || cmd[C_POFF] || resume_done)       susp_q <= 1'b0;
            else if (cmd[C_SUSP] && en_q && seq_idle)     susp_q <= 1'b1;
        end
    end

    // hardware events that set the change flags, and their clear requests
    always_comb begin
        flag_set         = '0;
        flag_set[F_CONN] = conn_q ^ connect_in;
        flag_set[F_EN]   = disc && en_q;
        flag_set[F_SUSP] = resume_done;
        flag_set[F_OVC]  = ovc_q ^ ovc_in;
        flag_set[F_RST]  = reset_done;
        flag_clr         = cmd[CH_BASE +: NFLAGS];
        flag_clr[F_SUSP] = cmd[CH_BASE + F_SUSP] || hub_rst_in;
    end

    rh_change_flags #(.N(NFLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    // port signalling drives
    always_comb begin
        drv_reset  = (seq_state == SEQ_RESET);
        drv_resume = (seq_state == SEQ_RESUME);
        drv_eop    = (seq_state == SEQ_EOP);
    end

    // read word assembly; reserved positions stay zero
    always_comb begin
        rd_data                        = '0;
        rd_data[B_CONN]                = conn_q;
        rd_data[B_EN]                  = en_q;
        rd_data[B_SUSP]                = susp_q;
        rd_data[B_OVC]                 = ovc_q;
        rd_data[B_RST]                 = drv_reset;
        rd_data[B_PWR]                 = pwr_q;
        rd_data[B_LS]                  = ls_q && conn_q;
        rd_data[CH_BASE +: NFLAGS]     = flags;
    end
endmodule

// File: rtl/rh_port_reg_chk.sv
// Assertion checker for rh_port_reg, attached by bind. It observes the
// ports and the sequencer completion pulses.
module rh_port_reg_chk
    import rh_port_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] rd_data,
    input logic             xact_busy,
    input logic             ovc_in,
    input logic             hub_rst_in,
    input logic             reset_done,
    input logic             resume_done,
    input logic             drv_reset,
    input logic             drv_resume,
    input logic             drv_eop
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RSVD_MASK) == '0);

    p_reset_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |=> (!rd_data[B_RST] && rd_data[CH_BASE + F_RST]));

    p_one_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_reset, drv_resume, drv_eop}));

    p_resume_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resume_done |=> (!rd_data[B_SUSP] && rd_data[CH_BASE + F_SUSP]));

    p_ovc_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_in != rd_data[B_OVC]) |=> rd_data[CH_BASE + F_OVC]);

    p_hub_rst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_rst_in && !resume_done) |=> !rd_data[CH_BASE + F_SUSP]);

    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_busy && rd_data[CH_BASE + F_RST]) |=> rd_data[CH_BASE + F_RST]);
endmodule

bind rh_port_reg rh_port_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .xact_busy   (xact_busy),
    .ovc_in      (ovc_in),
    .hub_rst_in  (hub_rst_in),
    .reset_done  (reset_done),
    .resume_done (resume_done),
    .drv_reset   (drv_reset),
    .drv_resume  (drv_resume),
    .drv_eop     (drv_eop)
);

// File: tb/rh_port_reg_tb_top.sv
`timescale 1ns/1ps
module rh_port_reg_tb_top;
    localparam int TICK = 4;
    localparam int RST_MS = 10;
    localparam int RES_MS = 20;
    localparam int SYN_MS = 3;
    localparam int RST_CYC = RST_MS * TICK;
    localparam int RES_CYC = RES_MS * TICK;
    localparam int SYN_CYC = SYN_MS * TICK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        xact_busy = 1'b0;
    logic        connect_in = 1'b0;
    logic        lowspeed_in = 1'b0;
    logic        ovc_in = 1'b0;
    logic        hub_rst_in = 1'b0;
    logic        drv_reset, drv_resume, drv_eop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rh_port_reg #(
        .TICK_CYCLES (TICK),
        .RESET_MS    (RST_MS),
        .RESUME_MS   (RES_MS),
        .RESYNC_MS   (SYN_MS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .xact_busy   (xact_busy),
        .connect_in  (connect_in),
        .lowspeed_in (lowspeed_in),
        .ovc_in      (ovc_in),
        .hub_rst_in  (hub_rst_in),
        .drv_reset   (drv_reset),
        .drv_resume  (drv_resume),
        .drv_eop     (drv_eop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R11 reset value", rd_data, 32'h0);

        connect_in = 1'b1; step();
        check("R6 connect and change", rd_data, 32'h0001_0001);
        write(32'h0000_0000);
        check("R4 zero write ignored", rd_data, 32'h0001_0001);
        write(32'h0001_0000);
        check("R4 connect change cleared", rd_data, 32'h0000_0001);
        write(32'hFFE0_FCE0);
        check("R1 reserved write ignored", rd_data, 32'h0000_0001);

        write(32'h0000_0002);
        check("R12 enable when connected", rd_data, 32'h0000_0003);
        write(32'h0000_0001);
        check("R12 disable", rd_data, 32'h0000_0001);
        write(32'h0000_0010);
        check("R12 reset ignored unpowered", {rd_data[31:0]}, 32'h0000_0001);
        write(32'h0000_0100);
        check("R12 power on", rd_data, 32'h0000_0101);
        lowspeed_in = 1'b1; step();
        check("R6 low speed shown", rd_data, 32'h0000_0301);
        lowspeed_in = 1'b0; step();

        // R2: cycle-by-cycle sweep of the reset interval
        write(32'h0000_0010);
        for (int k = 1; k <= RST_CYC + 1; k++) begin
            if (k > 1) step();
            check("R2 reset timing", {30'd0, rd_data[20], rd_data[4]},
                  (k <= RST_CYC) ? 32'h1 : 32'h2);
        end
        check("R2 enabled after reset", rd_data, 32'h0010_0103);
        write(32'h0010_0000);

        write(32'h0000_0004);
        check("R12 suspend when enabled", rd_data, 32'h0000_0107);

        // R3: cycle-by-cycle sweep of resume, eop and resync
        write(32'h0000_0008);
        for (int k = 1; k <= RES_CYC + 1 + SYN_CYC + 1; k++) begin
            if (k > 1) step();
            check("R3 resume timing",
                  {29'd0, rd_data[18], rd_data[2], drv_eop},
                  {29'd0, k > RES_CYC + 1 + SYN_CYC, k <= RES_CYC + 1 + SYN_CYC,
                   k == RES_CYC + 1});
        end
        check("R3 resume result", rd_data, 32'h0004_0103);
        hub_rst_in = 1'b1; step(); hub_rst_in = 1'b0;
        check("R8 hub reset clears suspend change", rd_data, 32'h0000_0103);

        // R9: clear held during a transaction
        write(32'h0000_0010);
        repeat (RST_CYC) step();
        check("R9 flag set before test", rd_data[20], 1'b1);
        xact_busy = 1'b1;
        write(32'h0010_0000);
        repeat (3) step();
        check("R9 clear postponed", rd_data[20], 1'b1);
        xact_busy = 1'b0; step();
        check("R9 clear after transaction", rd_data[20], 1'b0);

        ovc_in = 1'b1; step();
        check("R5 overcurrent rise", rd_data & 32'h0008_0008, 32'h0008_0008);
        write(32'h0008_0000);
        check("R4 overcurrent change cleared", rd_data[19], 1'b0);
        ovc_in = 1'b0;
        write(32'h0008_0000);
        check("R10 set wins over clear", rd_data & 32'h0008_0008, 32'h0008_0000);
        write(32'h0008_0000);

        connect_in = 1'b0; step();
        check("R7 disconnect", rd_data, 32'h0003_0100);
        write(32'h0000_0006);
        check("R12 no enable or suspend when detached", rd_data, 32'h0003_0100);
        write(32'h0000_0200);
        check("R12 power off", rd_data, 32'h0003_0000);

        finish_run();
    end
endmodule